// File: doc/BRIEF.md
# Event Timer Comparator Channel

One comparator channel of a high-precision event timer. The channel watches a shared, free-running 64-bit main count and requests an interrupt when that count reaches a programmed compare value. The channel works in one of two modes. In one-shot mode it fires once. In periodic mode it moves its own compare value forward by a stored period after every hit. A mode bit makes the channel compare and accumulate on the low 32 bits only.

Software reaches the channel through a 32-bit register port:
- The write side carries configuration, comparator words and an acknowledge.
- The read side returns configuration with capability flags, the comparator words and the period words.

The interrupt output can work in two ways. As a pulse, it is high for one cycle per event. As a level, it stays high until it is acknowledged. Requests come out only while both the channel enable and the global enable input are high. Bus decoding, the main counter and interrupt routing sit outside this block.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones in both words, the period reads zero, `irq_o` is low, and the configuration word (address 0) reads 0x60. In that word, bit 5 is the periodic capability flag and bit 6 is the 64-bit capability flag, and both always read 1. The writable bits are: bit 0 level type, bit 1 channel enable, bit 2 periodic, bit 3 set-value, bit 4 32-bit mode.
- R2: In one-shot mode the channel fires exactly once when the count reaches the comparator. The comparator value is left unchanged.
- R3: In periodic mode with a non-zero period, each hit adds the period to the comparator, one addition per cycle, until the comparator lies strictly ahead of the count. The test for "ahead" is a signed comparison of comparator minus count. In 32-bit mode the addition and the comparison are modulo 2^32.
- R4: A comparator write is at address 1 for the low word and 2 for the high word. It loads the comparator when the channel is in one-shot mode or the set-value bit is 1. A low-word write in periodic mode also stores the written value as the period's low word.
- R5: Any comparator write clears the set-value bit.
- R6: The period's top bit is forced to 0: bit 31 for a low-word write in 32-bit mode, and bit 63 for a high-word write. A high-word write in periodic mode with set-value at 0 changes only the period's high word (read at address 4) and leaves the comparator alone.
- R7: Writing the configuration with the 32-bit bit set clears the upper words of both the comparator and the period. While in 32-bit mode, high-word comparator writes change neither register.
- R8: In 32-bit one-shot mode, suppose the low count word would wrap (decrease) before reaching the comparator. Then the channel fires once at the wrap, and after that once at the real match.
- R9: If the comparator is already at or behind the count when the channel is armed, the channel fires on the next cycle and is never lost.
- R10: In pulse type (bit 0 = 0) each event gives a single-cycle `irq_o`. In level type `irq_o` stays high until a write to address 5.
- R11: While the channel enable or `glob_en_i` is low, `irq_o` falls at the next clock and no event is taken. A match that passes while disabled raises no interrupt.
- R12: The channel arms in three cases, each only while `glob_en_i` is high: a comparator write; a 0-to-1 write of the channel enable; or a rise of `glob_en_i` while the channel is enabled and the comparator is not all ones. Arming clears any pending wrap event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Shared main count |
| glob_en_i | input | 1 | Global enable for counting and interrupts |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0 config, 1 cmp low, 2 cmp high, 5 acknowledge) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address (0 config, 1/2 cmp, 3/4 period) |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches several properties on every cycle:
- gating by either enable drops the request (R11);
- a level request holds until it is acknowledged (R10);
- set-value clears after a comparator write (R5);
- the period's top bit never sets (R6);
- entering 32-bit mode truncates both registers (R7);
- an armed, reached compare yields a request on the next cycle (R9).

Other behaviours depend on the count moving over a long span, so only the bench's scenarios can show them:
- the number of periodic hits and where the comparator ends up (R3);
- the extra event at a 32-bit wrap (R8);
- the three ways of arming (R12).

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
   localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd1;
   localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd2;
   localparam logic [ADDR_W-1:0] A_PER_LO = 3'd3;
   localparam logic [ADDR_W-1:0] A_PER_HI = 3'd4;
   localparam logic [ADDR_W-1:0] A_ACK    = 3'd5;

   localparam int B_LVL  = 0;
   localparam int B_EN   = 1;
   localparam int B_PER  = 2;
   localparam int B_SET  = 3;
   localparam int B_M32  = 4;
   localparam int B_CAPP = 5;
   localparam int B_CAPW = 6;

   typedef struct packed {
      logic m32;
      logic setv;
      logic per;
      logic en;
      logic lvl;
   } cfg_t;
endpackage

// File: rtl/evt_cmp_dist.sv
module evt_cmp_dist #(
   parameter int CNT_W = 64
) (
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] period,
   input  logic             m32,
   input  logic             periodic,
   output logic             reached,
   output logic             wrap_init,
   output logic [CNT_W-1:0] adv
);
   localparam int H = CNT_W / 2;

   logic [CNT_W-1:0] diff_f;
   logic [H-1:0]     diff_h, dist_h, to_wrap;

   always_comb begin
      diff_f  = cmp - count;
      diff_h  = cmp[H-1:0] - count[H-1:0];
      reached = m32 ? (diff_h[H-1] | (diff_h == '0))
                    : (diff_f[CNT_W-1] | (diff_f == '0));
      dist_h    = reached ? {{(H-1){1'b0}}, 1'b1} : diff_h;
      to_wrap   = ~count[H-1:0];
      wrap_init = m32 & ~periodic & (to_wrap < dist_h);
      adv = m32 ? {{H{1'b0}}, cmp[H-1:0] + period[H-1:0]} : cmp + period;
   end
endmodule

// File: rtl/evt_cmp_wrapwatch.sv
module evt_cmp_wrapwatch #(
   parameter int LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LO_W-1:0] cnt_lo,
   output logic            wrapped
);
   logic [LO_W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cnt_lo;
   end

   assign wrapped = prev_q > cnt_lo;
endmodule

// File: rtl/evt_cmp_irq.sv
module evt_cmp_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic live,
   input  logic lvl,
   input  logic ack,
   output logic irq_o
);
   logic q;

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (lvl) q <= live & ((q & ~ack) | fire);
      else          q <= live & fire;
   end

   assign irq_o = q;
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
   import evt_cmp_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              glob_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   localparam int H = CNT_W / 2;

   if (CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("evt_cmp_channel: CNT_W must be twice DATA_W");
   end

   cfg_t             cfg_q;
   logic [CNT_W-1:0] cmp_q, per_q, adv;
   logic arm_req, armed, catchup, wrap_pend, glob_q;
   logic live, reached, wrap_init, wrapped, fire;
   logic wr_cfg, wr_lo, wr_hi, ack, load_ok, glob_rise;

   assign live      = cfg_q.en & glob_en_i;
   assign glob_rise = glob_en_i & ~glob_q;
   assign wr_cfg    = wr_en_i & (wr_addr_i == A_CFG);
   assign wr_lo     = wr_en_i & (wr_addr_i == A_CMP_LO);
   assign wr_hi     = wr_en_i & (wr_addr_i == A_CMP_HI);
   assign ack       = wr_en_i & (wr_addr_i == A_ACK);
   assign load_ok   = ~cfg_q.per | cfg_q.setv;
   assign fire      = live & armed & ~catchup & (wrap_pend ? wrapped : reached);

   evt_cmp_dist #(.CNT_W(CNT_W)) u_dist (
      .cmp(cmp_q), .count(count_i), .period(per_q), .m32(cfg_q.m32),
      .periodic(cfg_q.per), .reached(reached), .wrap_init(wrap_init), .adv(adv)
   );

   evt_cmp_wrapwatch #(.LO_W(H)) u_wrap (
      .clk(clk), .rst_n(rst_n), .cnt_lo(count_i[H-1:0]), .wrapped(wrapped)
   );

   evt_cmp_irq u_irq (
      .clk(clk), .rst_n(rst_n), .fire(fire), .live(live),
      .lvl(cfg_q.lvl), .ack(ack), .irq_o(irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         cmp_q     <= '1;
         per_q     <= '0;
         arm_req   <= 1'b0;
         armed     <= 1'b0;
         catchup   <= 1'b0;
         wrap_pend <= 1'b0;
         glob_q    <= 1'b0;
      end else begin
         glob_q  <= glob_en_i;
         arm_req <= glob_en_i & (wr_lo | wr_hi
                    | (wr_cfg & wr_data_i[B_EN] & ~cfg_q.en)
                    | (glob_rise & cfg_q.en & ~(&cmp_q)));

         // channel sequencing
         if (!live) begin
            armed     <= 1'b0;
            catchup   <= 1'b0;
            wrap_pend <= 1'b0;
         end else if (arm_req) begin
            armed     <= 1'b1;
            catchup   <= 1'b0;
            wrap_pend <= wrap_init;
         end else if (fire) begin
            if (wrap_pend) begin
               wrap_pend <= 1'b0;
            end else if (cfg_q.per && per_q != '0) begin
               catchup <= 1'b1;
               cmp_q   <= adv;
            end else begin
               armed <= 1'b0;
            end
         end else if (catchup) begin
            if (reached) cmp_q   <= adv;
            else         catchup <= 1'b0;
         end

         // register writes override sequencing
         if (wr_cfg) begin
            cfg_q.lvl  <= wr_data_i[B_LVL];
            cfg_q.en   <= wr_data_i[B_EN];
            cfg_q.per  <= wr_data_i[B_PER];
            cfg_q.setv <= wr_data_i[B_SET];
            cfg_q.m32  <= wr_data_i[B_M32];
            if (wr_data_i[B_M32]) begin
               cmp_q <= {{H{1'b0}}, cmp_q[H-1:0]};
               per_q <= {{H{1'b0}}, per_q[H-1:0]};
            end
         end
         if (wr_lo) begin
            cfg_q.setv <= 1'b0;
            if (load_ok) cmp_q[H-1:0] <= wr_data_i;
            if (cfg_q.per)
               per_q[H-1:0] <= cfg_q.m32 ? {1'b0, wr_data_i[H-2:0]} : wr_data_i;
         end
         if (wr_hi) begin
            cfg_q.setv <= 1'b0;
            if (!cfg_q.m32) begin
               if (load_ok) cmp_q[CNT_W-1:H] <= wr_data_i;
               else         per_q[CNT_W-1:H] <= {1'b0, wr_data_i[H-2:0]};
            end
         end
      end
   end

   always_comb begin
      unique case (rd_addr_i)
         A_CFG:    rd_data_o = {{(DATA_W-7){1'b0}}, 1'b1, 1'b1, cfg_q};
         A_CMP_LO: rd_data_o = cmp_q[H-1:0];
         A_CMP_HI: rd_data_o = cmp_q[CNT_W-1:H];
         A_PER_LO: rd_data_o = per_q[H-1:0];
         A_PER_HI: rd_data_o = per_q[CNT_W-1:H];
         default:  rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glob_en_i,
   input logic             irq_o,
   input logic             cfg_en,
   input logic             cfg_lvl,
   input logic             cfg_setv,
   input logic             ack,
   input logic             wr_cmp,
   input logic             wr_m32,
   input logic             armed,
   input logic             catchup,
   input logic             wrap_pend,
   input logic             reached,
   input logic [CNT_W-1:0] cmp_q,
   input logic [CNT_W-1:0] per_q
);
   localparam int H = CNT_W / 2;

   a_r11_glob_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en_i |=> !irq_o);
   a_r11_chan_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !irq_o);
   a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_lvl && irq_o && cfg_en && glob_en_i && !ack) |=> irq_o);
   a_r5_setv_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp |=> !cfg_setv);
   a_r6_period_top: assert property (@(posedge clk) disable iff (!rst_n)
      !per_q[CNT_W-1]);
   a_r7_truncate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_m32 |=> (cmp_q[CNT_W-1:H] == '0 && per_q[CNT_W-1:H] == '0));
   a_r9_prompt: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && glob_en_i && armed && !catchup && !wrap_pend && reached) |=> irq_o);
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .glob_en_i(glob_en_i), .irq_o(irq_o),
   .cfg_en(cfg_q.en), .cfg_lvl(cfg_q.lvl), .cfg_setv(cfg_q.setv), .ack(ack),
   .wr_cmp(wr_lo | wr_hi), .wr_m32(wr_cfg & wr_data_i[evt_cmp_pkg::B_M32]),
   .armed(armed), .catchup(catchup), .wrap_pend(wrap_pend), .reached(reached),
   .cmp_q(cmp_q), .per_q(per_q)
);

// File: tb/evt_cmp_channel_tb.sv
module evt_cmp_channel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        glob = 1'b0, we = 1'b0;
   logic [2:0]  wa = '0, ra = '0;
   logic [31:0] wd = '0;
   logic [31:0] rd;
   logic        irq;

   logic        run = 1'b0, ld = 1'b0;
   logic [63:0] ld_val = '0;
   int checks = 0, errs = 0, cyc_checks = 0, cyc_errs = 0, pulses = 0;
   logic cmp_on = 1'b0, done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   evt_cmp_channel u_dut (
      .clk(clk), .rst_n(rst_n), .count_i(cnt), .glob_en_i(glob),
      .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
      .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
   );

   always @(negedge clk) begin
      if (ld) cnt <= ld_val;
      else if (run) cnt <= cnt + 64'd1;
   end

   // behavioural reference model
   logic m_lvl, m_en, m_per, m_set, m_32, m_irq, m_armreq, m_armed, m_catch, m_wrap, m_gq;
   logic [63:0] m_cmp, m_pv, t_d64, t_adv;
   logic [31:0] m_prev, t_d32, t_dist;
   logic t_live, t_reach, t_fire, t_winit, t_ack, t_ld;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_lvl, m_en, m_per, m_set, m_32} <= '0;
         {m_irq, m_armreq, m_armed, m_catch, m_wrap, m_gq} <= '0;
         m_cmp <= '1; m_pv <= '0; m_prev <= '0;
      end else begin
         t_live  = m_en && glob;
         t_d64   = m_cmp - cnt;
         t_d32   = m_cmp[31:0] - cnt[31:0];
         t_reach = m_32 ? ($signed(t_d32) <= 0) : ($signed(t_d64) <= 0);
         t_fire  = t_live && m_armed && !m_catch && (m_wrap ? (m_prev > cnt[31:0]) : t_reach);
         t_adv   = m_32 ? {32'd0, m_cmp[31:0] + m_pv[31:0]} : m_cmp + m_pv;
         t_dist  = t_reach ? 32'd1 : t_d32;
         t_winit = m_32 && !m_per && ((32'hFFFF_FFFF - cnt[31:0]) < t_dist);
         t_ack   = we && wa == 3'd5;
         t_ld    = !m_per || m_set;
         m_irq   <= m_lvl ? (t_live && ((m_irq && !t_ack) || t_fire)) : (t_live && t_fire);
         m_prev  <= cnt[31:0];
         m_gq    <= glob;
         m_armreq <= glob && ((we && (wa == 3'd1 || wa == 3'd2))
                     || (we && wa == 3'd0 && wd[1] && !m_en)
                     || (!m_gq && m_en && m_cmp != '1));
         if (!t_live) begin
            m_armed <= 0; m_catch <= 0; m_wrap <= 0;
         end else if (m_armreq) begin
            m_armed <= 1; m_catch <= 0; m_wrap <= t_winit;
         end else if (t_fire) begin
            if (m_wrap) m_wrap <= 0;
            else if (m_per && m_pv != 0) begin m_catch <= 1; m_cmp <= t_adv; end
            else m_armed <= 0;
         end else if (m_catch) begin
            if (t_reach) m_cmp <= t_adv; else m_catch <= 0;
         end
         if (we && wa == 3'd0) begin
            m_lvl <= wd[0]; m_en <= wd[1]; m_per <= wd[2]; m_set <= wd[3]; m_32 <= wd[4];
            if (wd[4]) begin m_cmp <= {32'd0, m_cmp[31:0]}; m_pv <= {32'd0, m_pv[31:0]}; end
         end
         if (we && wa == 3'd1) begin
            m_set <= 0;
            if (t_ld) m_cmp[31:0] <= wd;
            if (m_per) m_pv[31:0] <= m_32 ? {1'b0, wd[30:0]} : wd;
         end
         if (we && wa == 3'd2) begin
            m_set <= 0;
            if (!m_32) begin
               if (t_ld) m_cmp[63:32] <= wd;
               else m_pv[63:32] <= {1'b0, wd[30:0]};
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         cyc_checks++;
         if (irq !== m_irq) begin
            cyc_errs++;
            $display("FAIL %s irq per-cycle: actual %0b expected %0b", cur_req, irq, m_irq);
         end
         if (irq) pulses++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #2; we = 1; wa = a; wd = d;
      @(posedge clk); #2; we = 0;
   endtask

   task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
      @(posedge clk); #2; ra = a; #1;
      chk(req, rd, exp);
   endtask

   task automatic load(input logic [63:0] v);
      @(posedge clk); #2; ld = 1; ld_val = v;
      @(posedge clk); #2; ld = 0;
   endtask

   task automatic set_glob(input logic v);
      @(posedge clk); #2; glob = v;
   endtask

   task automatic wait_cnt(input logic [63:0] v);
      while (cnt < v) @(posedge clk);
      #2;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks + cyc_checks, errs + cyc_errs);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int base;
      repeat (4) @(posedge clk);
      #2; rst_n = 1; cmp_on = 1;
      // R1 reset state
      rdchk("R1", 3'd0, 32'h60);
      rdchk("R1", 3'd1, 32'hFFFF_FFFF);
      rdchk("R1", 3'd2, 32'hFFFF_FFFF);
      rdchk("R1", 3'd3, 32'h0);
      rdchk("R1", 3'd4, 32'h0);
      chk("R1", {31'd0, irq}, 32'd0);

      // R2 one-shot 64-bit
      cur_req = "R2";
      load(64'd0); run = 1;
      wr(3'd0, 32'h02); wr(3'd1, 32'd100); wr(3'd2, 32'd0);
      base = pulses;
      set_glob(1);
      wait_cnt(64'd300);
      chk("R2", pulses - base, 32'd1);
      rdchk("R2", 3'd1, 32'd100);
      set_glob(0); waitc(1);
      chk("R11", {31'd0, irq}, 32'd0);

      // R3/R4/R5 periodic 64-bit
      cur_req = "R3";
      load(64'd0);
      wr(3'd0, 32'h0E); wr(3'd2, 32'd0);
      wr(3'd0, 32'h0E); wr(3'd1, 32'd50);
      rdchk("R4", 3'd3, 32'd50);
      rdchk("R4", 3'd1, 32'd50);
      rdchk("R5", 3'd0, 32'h66);
      base = pulses;
      set_glob(1);
      wait_cnt(64'd525);
      chk("R3", pulses - base, 32'd10);
      rdchk("R3", 3'd1, 32'd550);
      set_glob(0);

      // R6 clamp
      cur_req = "R6";
      wr(3'd0, 32'h14);
      wr(3'd1, 32'hFFFF_FFFF);
      rdchk("R6", 3'd3, 32'h7FFF_FFFF);
      rdchk("R6", 3'd1, 32'd550);
      wr(3'd0, 32'h04);
      wr(3'd2, 32'hFFFF_FFFF);
      rdchk("R6", 3'd4, 32'h7FFF_FFFF);
      rdchk("R6", 3'd2, 32'd0);

      // R4/R7 high word and truncation
      cur_req = "R7";
      wr(3'd0, 32'h00);
      wr(3'd2, 32'h1234_5678);
      rdchk("R4", 3'd2, 32'h1234_5678);
      wr(3'd0, 32'h10);
      rdchk("R7", 3'd2, 32'd0);
      rdchk("R7", 3'd4, 32'd0);
      wr(3'd2, 32'h0000_ABCD);
      rdchk("R7", 3'd2, 32'd0);

      // R8 32-bit one-shot wrap
      cur_req = "R8";
      wr(3'd0, 32'h12);
      load(64'h0000_0000_FFFF_FF00);
      wr(3'd1, 32'h20);
      base = pulses;
      set_glob(1);
      wait_cnt(64'h0000_0001_0000_0040);
      chk("R8", pulses - base, 32'd2);
      set_glob(0);

      // R9 already-past compare fires promptly
      cur_req = "R9";
      load(64'd1000);
      wr(3'd0, 32'h02); wr(3'd1, 32'd10); wr(3'd2, 32'd0);
      base = pulses;
      set_glob(1);
      waitc(5);
      chk("R9", pulses - base, 32'd1);
      waitc(50);
      chk("R9", pulses - base, 32'd1);
      set_glob(0);

      // R10 level hold and acknowledge
      cur_req = "R10";
      load(64'd0);
      wr(3'd0, 32'h03); wr(3'd1, 32'd20);
      set_glob(1);
      wait_cnt(64'd60);
      chk("R10", {31'd0, irq}, 32'd1);
      waitc(10);
      chk("R10", {31'd0, irq}, 32'd1);
      wr(3'd5, 32'd0);
      chk("R10", {31'd0, irq}, 32'd0);

      // R12 re-arm by comparator write, R11 gating
      cur_req = "R12";
      wr(3'd1, 32'd200);
      wait_cnt(64'd230);
      chk("R12", {31'd0, irq}, 32'd1);
      set_glob(0); waitc(1);
      chk("R11", {31'd0, irq}, 32'd0);
      cur_req = "R11";
      wr(3'd0, 32'h01);
      set_glob(1);
      wr(3'd1, 32'd400);
      wait_cnt(64'd450);
      chk("R11", {31'd0, irq}, 32'd0);
      cur_req = "R12";
      wr(3'd0, 32'h03);
      waitc(3);
      chk("R12", {31'd0, irq}, 32'd1);
      set_glob(0);
      waitc(3);

      done = 1;
      summary();
      $finish;
   end
endmodule